// File: doc/BRIEF.md
# Fixed-Width Line Printer Formatter

This block turns one sampled line of readings into the character stream for a line printer that holds one line in its own buffer. A line is a time value followed by a configurable number of signed channel readings. Each reading has a half digit (0 or 1), three BCD digits, a sign and a count of digits after the decimal point. Every reading becomes a field of exactly six columns. When the half digit is 1 it is not printed; instead the decimal-point character becomes '$', so the field keeps its six columns while the count range reaches 1999.

A start strobe copies all readings into the block. The block then sends one character per strobe and ends the line with a carriage return, which makes the printer print. After that it waits out the printer's busy period and reports completion with a one-cycle flag. The printer's busy line stalls the character stream at any point. A start request made while a line is in progress is held and served once the block is idle again.

Top module: `lpf_line_fmt`

## Requirements
- R1: While reset is high and after reset with no start request, `char_stb_o` and `done_o` stay 0.
- R2: Each channel field is six characters: a space (0x20), then '-' (0x2D) if the sign bit [15] is 1 or '+' (0x2B) if it is 0, then four body characters.
- R3: The body holds the three digits, most significant first: bits [11:8], then [7:4], then [3:0]. Each digit is printed as 0x30 plus its value. The point character sits in front of the last F digits, where F is bits [13:12] (0 to 3). F=0 puts the point after all three digits.
- R4: The point character is '$' (0x24) when the half-digit bit [14] is 1 and '.' (0x2E) when it is 0. The half digit itself is never printed.
- R5: The time field comes first in the line. It uses the same layout, except that its sign column is always a space (0x20), whatever bit [15] holds.
- R6: After the time field come the channel fields in index order 0 to N_CH-1, then one carriage return (0x0D). A line is 6*(N_CH+1)+1 characters, and no character follows the carriage return within that line.
- R7: A character strobe appears only in the cycle after a clock edge at which `busy_i` was low. A stalled line resumes with no character lost or repeated.
- R8: After the carriage return, `done_o` pulses for exactly one cycle. It is visible in the cycle after the first edge that sees `busy_i` low again, once busy has been seen high. If busy does not rise within WAIT_MAX cycles of the carriage return, the pulse comes exactly WAIT_MAX cycles after it.
- R9: A start request made while a line is sent or while the block waits on busy is held. Exactly one further line begins once the block is idle, however many requests arrived in the meantime.
- R10: Bit 7 of every character sent is 0.
- R11: The readings are copied in the cycle the line begins. Input changes after that do not alter the line being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Line request strobe |
| time_i | input | 16 | Time reading: {sign, half, frac[1:0], d2, d1, d0} |
| chan_i | input | 16*N_CH | Channel readings, channel k at bits [16k+15:16k], same layout |
| busy_i | input | 1 | Printer busy; no character is sent while high |
| char_o | output | 8 | ASCII character |
| char_stb_o | output | 1 | Character valid this cycle |
| done_o | output | 1 | One-cycle line-complete pulse |

## Verification
A wrong field or column counter shows up at once in the character stream. A character moves, a sign or point column gets the wrong code, or the line length differs from 6*(N_CH+1)+1, and all of this is seen on the first affected strobe. A damaged wait state shows as a completion pulse that comes early, late or twice, measured in exact cycles against the busy release or the timeout. A lost or repeated request latch shows within a few hundred cycles as a missing or surplus line. A snapshot fault shows as a line carrying data written after its start.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

    // One reading: sign, half digit, digits after point, three BCD digits (dig[2] is most significant)
    typedef struct packed {
        logic            neg;
        logic            half;
        logic [1:0]      frac;
        logic [2:0][3:0] dig;
    } fld_t;

    localparam int FLD_W = 16;
    localparam int COLS  = 6;

    localparam logic [7:0] C_SP     = 8'h20;
    localparam logic [7:0] C_PLUS   = 8'h2B;
    localparam logic [7:0] C_MINUS  = 8'h2D;
    localparam logic [7:0] C_DOT    = 8'h2E;
    localparam logic [7:0] C_DOLLAR = 8'h24;
    localparam logic [7:0] C_CR     = 8'h0D;
    localparam logic [7:0] C_ZERO   = 8'h30;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SEND,
        S_WAIT_HI,
        S_WAIT_LO
    } st_t;

    function automatic logic [7:0] bcd_char(input logic [3:0] d);
        return C_ZERO + {4'h0, d};
    endfunction

endpackage

// File: rtl/lpf_char_gen.sv
module lpf_char_gen
    import lpf_pkg::*;
(
    input  fld_t       fld,
    input  logic       is_time,
    input  logic [2:0] col,
    output logic [7:0] ch
);

    logic [1:0] pt;
    logic [1:0] p;
    logic [1:0] idx;

    always_comb begin
        pt  = 2'd3 - fld.frac;
        p   = 2'(col - 3'd2);
        idx = 2'd0;
        ch  = C_SP;
        case (col)
            3'd0: ch = C_SP;
            3'd1: ch = is_time ? C_SP : (fld.neg ? C_MINUS : C_PLUS);
            default: begin
                if (p < pt) begin
                    idx = 2'd2 - p;
                    ch  = bcd_char(fld.dig[idx]);
                end else if (p == pt) begin
                    ch = fld.half ? C_DOLLAR : C_DOT;
                end else begin
                    idx = 2'd3 - p;
                    ch  = bcd_char(fld.dig[idx]);
                end
            end
        endcase
    end

endmodule

// File: rtl/lpf_ctrl.sv
module lpf_ctrl
    import lpf_pkg::*;
#(
    parameter int N_CH     = 20,
    parameter int WAIT_MAX = 1024,
    localparam int NF      = N_CH + 1,
    localparam int FW      = $clog2(NF + 1),
    localparam int WW      = $clog2(WAIT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          busy_i,
    output logic          load_o,
    output logic          emit_o,
    output logic          last_o,
    output logic [FW-1:0] fidx_o,
    output logic [2:0]    col_o,
    output logic          done_o
);

    st_t           st;
    logic          pend;
    logic [FW-1:0] fidx;
    logic [2:0]    col;
    logic [WW-1:0] wcnt;

    assign load_o = (st == S_IDLE) && (start_i || pend);
    assign emit_o = (st == S_SEND) && !busy_i;
    assign last_o = (fidx == FW'(NF));
    assign fidx_o = fidx;
    assign col_o  = col;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            pend   <= 1'b0;
            fidx   <= '0;
            col    <= '0;
            wcnt   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && st != S_IDLE) pend <= 1'b1;
            case (st)
                S_IDLE: begin
                    if (start_i || pend) begin
                        st   <= S_SEND;
                        pend <= 1'b0;
                        fidx <= '0;
                        col  <= '0;
                    end
                end
                S_SEND: begin
                    if (!busy_i) begin
                        if (last_o) begin
                            st   <= S_WAIT_HI;
                            wcnt <= '0;
                        end else if (col == 3'(COLS - 1)) begin
                            col  <= '0;
                            fidx <= fidx + 1'b1;
                        end else begin
                            col <= col + 1'b1;
                        end
                    end
                end
                S_WAIT_HI: begin
                    if (busy_i) begin
                        st <= S_WAIT_LO;
                    end else if (wcnt == WW'(WAIT_MAX - 1)) begin
                        st     <= S_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                S_WAIT_LO: begin
                    if (!busy_i) begin
                        st     <= S_IDLE;
                        done_o <= 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lpf_line_fmt.sv
module lpf_line_fmt
    import lpf_pkg::*;
#(
    parameter int N_CH     = 20,
    parameter int WAIT_MAX = 1024,
    localparam int NF      = N_CH + 1,
    localparam int FW      = $clog2(NF + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [FLD_W-1:0]      time_i,
    input  logic [FLD_W*N_CH-1:0] chan_i,
    input  logic                  busy_i,
    output logic [7:0]            char_o,
    output logic                  char_stb_o,
    output logic                  done_o
);

    logic          load;
    logic          emit;
    logic          last;
    logic [FW-1:0] fidx;
    logic [2:0]    col;
    fld_t          snap [0:NF-1];
    fld_t          cur;
    logic [7:0]    gen_ch;

    lpf_ctrl #(.N_CH(N_CH), .WAIT_MAX(WAIT_MAX)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_i  (busy_i),
        .load_o  (load),
        .emit_o  (emit),
        .last_o  (last),
        .fidx_o  (fidx),
        .col_o   (col),
        .done_o  (done_o)
    );

    for (genvar k = 0; k < NF; k++) begin : g_snap
        always_ff @(posedge clk) begin
            if (load) begin
                if (k == 0) snap[k] <= fld_t'(time_i);
                else        snap[k] <= fld_t'(chan_i[(k-1)*FLD_W +: FLD_W]);
            end
        end
    end

    always_comb begin
        cur = '0;
        if (fidx < FW'(NF)) cur = snap[fidx];
    end

    lpf_char_gen u_gen (
        .fld     (cur),
        .is_time (fidx == '0),
        .col     (col),
        .ch      (gen_ch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            char_stb_o <= 1'b0;
            char_o     <= '0;
        end else begin
            char_stb_o <= emit;
            if (emit) char_o <= last ? C_CR : gen_ch;
        end
    end

endmodule

// File: rtl/lpf_chk.sv
module lpf_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy_i,
    input logic [7:0] char_o,
    input logic       char_stb_o,
    input logic       done_o
);

    a_r7_no_char_when_busy: assert property (@(posedge clk) disable iff (rst)
        char_stb_o |-> $past(!busy_i));

    a_r10_seven_bit: assert property (@(posedge clk) disable iff (rst)
        char_stb_o |-> !char_o[7]);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_done_after_release: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(!busy_i) && !char_stb_o));

    a_r6_quiet_after_cr: assert property (@(posedge clk) disable iff (rst)
        (char_stb_o && char_o == 8'h0D) |=> !char_stb_o);

endmodule

bind lpf_line_fmt lpf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy_i),
    .char_o     (char_o),
    .char_stb_o (char_stb_o),
    .done_o     (done_o)
);

// File: tb/sim_lpf_line_fmt.sv
`timescale 1ns/1ps
module sim_lpf_line_fmt;

    localparam int N    = 16;
    localparam int WMAX = 64;
    localparam int LINE = 6 * (N + 1) + 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [15:0]     tv = '0;
    logic [15:0]     cv [0:N-1];
    logic [16*N-1:0] chan;
    logic            busy;
    logic [7:0]      ch;
    logic            stb;
    logic            done;

    always #2.5 clk = ~clk;

    always_comb for (int k = 0; k < N; k++) chan[16*k +: 16] = cv[k];

    lpf_line_fmt #(.N_CH(N), .WAIT_MAX(WMAX)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .time_i(tv), .chan_i(chan),
        .busy_i(busy), .char_o(ch), .char_stb_o(stb), .done_o(done)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // printer and observation model, all at the falling edge
    logic       busy_prn = 1'b0;
    logic       busy_pat = 1'b0;
    bit         prn_en = 1'b1;
    bit         pat_en = 1'b0;
    int         prn_cnt = 0;
    int         cyc = 0;
    int         cyc_cr = 0, cyc_fall = 0, cyc_done = 0;
    int         gn = 0, dn = 0;
    logic [7:0] got [0:1023];
    logic       b_q = 1'b0;

    assign busy = busy_prn | busy_pat;

    always @(posedge clk) b_q <= busy;

    always @(negedge clk) begin
        cyc++;
        if (stb) begin
            chk(!b_q, "R7 strobe after busy edge", 1, 0);
            chk(ch[7] == 1'b0, "R10 bit7", ch, ch & 8'h7F);
            if (gn < 1024) got[gn] = ch;
            gn++;
            if (ch == 8'h0D) cyc_cr = cyc;
        end
        if (done) begin
            dn++;
            cyc_done = cyc;
        end
        if (prn_en && stb && ch == 8'h0D) begin
            busy_prn = 1'b1;
            prn_cnt  = 40;
        end else if (prn_cnt > 0) begin
            prn_cnt--;
            if (prn_cnt == 0) begin
                busy_prn = 1'b0;
                cyc_fall = cyc;
            end
        end
        busy_pat = pat_en && ((cyc % 5) < 2);
    end

    // expected line model
    logic [15:0] et;
    logic [15:0] ec [0:N-1];

    function automatic logic [7:0] ech(input logic [15:0] f, input bit tm, input int col);
        logic [7:0] b [0:3];
        logic [7:0] dg [0:2];
        int fr, j;
        fr = int'(f[13:12]);
        dg[0] = 8'h30 + {4'h0, f[11:8]};
        dg[1] = 8'h30 + {4'h0, f[7:4]};
        dg[2] = 8'h30 + {4'h0, f[3:0]};
        j = 0;
        for (int p = 0; p < 4; p++) begin
            if (p == 3 - fr) b[p] = f[14] ? "$" : ".";
            else begin
                b[p] = dg[j];
                j++;
            end
        end
        if (col == 0) return " ";
        if (col == 1) return tm ? " " : (f[15] ? "-" : "+");
        return b[col-2];
    endfunction

    task automatic check_line(input int base, input string nm);
        logic [7:0] e;
        string tg;
        chk(gn - base == LINE, {"R6 line length ", nm}, gn - base, LINE);
        for (int fi = 0; fi <= N; fi++) begin
            for (int c = 0; c < 6; c++) begin
                e = (fi == 0) ? ech(et, 1'b1, c) : ech(ec[fi-1], 1'b0, c);
                if (c <= 1) tg = (fi == 0) ? "R5 time field" : "R2 sign/space";
                else if (e == "$" || e == ".") tg = "R4 point char";
                else tg = "R3 digit";
                chk(got[base + fi*6 + c] == e, {tg, " ", nm}, got[base + fi*6 + c], e);
            end
        end
        chk(got[base + LINE - 1] == 8'h0D, {"R6 carriage return ", nm}, got[base + LINE - 1], 8'h0D);
    endtask

    task automatic wait_done(input int target, input string nm);
        int t;
        t = 0;
        while (dn < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(dn >= target, {"R8 done arrives ", nm}, dn, target);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_pat(input int sel);
        for (int k = 0; k < N; k++) begin
            if (sel == 0)
                cv[k] = {k[0], k[1], k[3:2], 4'((k+1)%10), 4'((k*3+2)%10), 4'((k*7+5)%10)};
            else
                cv[k] = {k[3], k[2], k[1:0], 4'((k+6)%10), 4'((k*9+4)%10), 4'((k*3+8)%10)};
        end
        tv = (sel == 0) ? {1'b1, 1'b0, 2'd1, 4'd3, 4'd1, 4'd6} : {1'b0, 1'b1, 2'd2, 4'd9, 4'd0, 4'd7};
    endtask

    task automatic copy_exp();
        et = tv;
        for (int k = 0; k < N; k++) ec[k] = cv[k];
    endtask

    initial begin
        #400000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base, d0, g0;
        set_pat(0);
        repeat (3) @(negedge clk);
        chk(stb == 1'b0, "R1 strobe in reset", stb, 0);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(gn == 0, "R1 idle after reset", gn, 0);
        chk(dn == 0, "R1 no done after reset", dn, 0);

        // line 1: every sign/half/frac combination, printer busy after CR
        copy_exp();
        base = gn;
        pulse_start();
        wait_done(1, "line1");
        check_line(base, "line1");
        chk(cyc_done == cyc_fall + 1, "R8 done after busy release", cyc_done, cyc_fall + 1);

        // line 2: busy stalls during send
        set_pat(1);
        copy_exp();
        base = gn;
        pat_en = 1'b1;
        pulse_start();
        wait_done(2, "line2");
        pat_en = 1'b0;
        check_line(base, "line2 stalled R7");

        // line 3: printer never raises busy, timeout completion
        repeat (5) @(negedge clk);
        prn_en = 1'b0;
        set_pat(0);
        copy_exp();
        base = gn;
        pulse_start();
        wait_done(3, "line3");
        check_line(base, "line3");
        chk(cyc_done == cyc_cr + WMAX, "R8 timeout completion", cyc_done - cyc_cr, WMAX);
        prn_en = 1'b1;

        // line 4/5: held request and snapshot
        repeat (5) @(negedge clk);
        set_pat(0);
        copy_exp();
        base = gn;
        d0 = dn;
        pulse_start();
        while (gn < base + 10) @(negedge clk);
        pulse_start();
        pulse_start();
        set_pat(1);
        wait_done(d0 + 1, "line4");
        check_line(base, "line4 R11 snapshot");
        copy_exp();
        base = gn;
        wait_done(d0 + 2, "line5");
        check_line(base, "line5 R9 held request");
        g0 = gn;
        repeat (300) @(negedge clk);
        chk(gn == g0, "R9 single extra line", gn - g0, 0);
        chk(dn == d0 + 2, "R9 done count", dn, d0 + 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule